// File: doc/BRIEF.md
# SECDED Hamming Codec

This block protects a memory data word with a Hamming code that corrects any one flipped bit and detects any two flipped bits. The encoder side takes a data word and produces a codeword. The data bits sit at the non-power-of-two positions and the check bits sit at the power-of-two positions. An overall even-parity bit is appended after the last position. The decoder side takes a codeword read back from storage and recomputes every check to form a syndrome. When the syndrome is nonzero, its value is the position of the bad bit. The decoder also tests overall parity.

The decoder combines "syndrome is zero or nonzero" with "overall parity matches or not" to reach one of three verdicts:
- CLEAN: zero syndrome, parity matches.
- FIXED: nonzero syndrome with a parity mismatch, where the named bit is flipped back, or zero syndrome with a parity mismatch, where only the appended parity bit was hit.
- DOUBLE: nonzero syndrome with matching parity, or a syndrome that points past the last position. The word is flagged and left uncorrected.

Encoder and decoder are purely combinational and share only the code layout. The default width is 4 data bits, which gives 3 position checks plus the parity bit, so the codeword is 8 bits.

Top module: `secded_codec`

## Requirements
- R1: With 4 data bits, codeword bit k-1 holds position k. Positions 1 to 7 hold c1, c2, d1, c3, d2, d3, d4, and c4 is codeword bit 7. d1 is data bit 0 and d4 is data bit 3.
- R2: c1 = d1^d2^d4, c2 = d1^d3^d4 and c3 = d2^d3^d4.
- R3: c4 makes the XOR of all eight codeword bits zero.
- R4: An unmodified codeword decodes with only the no-error output high, and the data output equals the encoded data.
- R5: Flipping any one of codeword bits 0 to 6 decodes with only the corrected output high, and the data output equals the original data.
- R6: Flipping only codeword bit 7 decodes with only the corrected output high, and the data output equals the original data.
- R7: Flipping any two distinct codeword bits decodes with only the double-error output high. The data output is then the raw bits at codeword bits 2, 4, 5 and 6, taken as data bits 0 to 3.
- R8: Exactly one of the three status outputs is high for every decoded word.
- R9: Data 4'b0110 encodes to 8'h33, so c1=1, c2=1 and c3=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | 4 | Data word to encode |
| code_out | output | 8 | Encoded codeword |
| code_in | input | 8 | Codeword read back, to decode |
| data_out | output | 4 | Decoded (repaired or raw) data word |
| no_err | output | 1 | Verdict CLEAN |
| corrected | output | 1 | Verdict FIXED |
| double_err | output | 1 | Verdict DOUBLE |

## Verification
The cases hardest to reach from the ports are the ones where the data is correct but the status is not clean. These are a flip of the appended parity bit alone, and single flips that land on a check position, where the syndrome names a check bit rather than a data bit. Both can only be produced by corrupting a valid codeword in exactly that bit. The stimulus therefore builds the valid codeword of every data value arithmetically. It applies every one-bit mask and every two-bit mask to that codeword, so each syndrome value is met together with both parity outcomes.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [1:0] {
        DEC_CLEAN  = 2'd0,
        DEC_FIXED  = 2'd1,
        DEC_DOUBLE = 2'd2
    } dec_verdict_e;

    // number of position checks so that every position fits in the syndrome
    function automatic int chk_count(input int data_w);
        int p;
        p = 0;
        while ((1 << p) < data_w + p + 1) p++;
        return p;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

    // codeword position (1-based) of data bit j
    function automatic int data_pos(input int j);
        int seen;
        seen = 0;
        for (int pos = 1; pos < 4096; pos++) begin
            if (!is_pow2(pos)) begin
                if (seen == j) return pos;
                seen++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0]                      data_i,
    output logic [DATA_W+chk_count(DATA_W):0]      code_o
);
    localparam int CHK_W = chk_count(DATA_W);
    localparam int NPOS  = DATA_W + CHK_W;

    logic [NPOS:0] word;

    always_comb begin
        word = '0;
        for (int j = 0; j < DATA_W; j++) begin
            word[data_pos(j) - 1] = data_i[j];
        end
        for (int i = 0; i < CHK_W; i++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p <= NPOS; p++) begin
                if ((p & (1 << i)) != 0) acc = acc ^ word[p - 1];
            end
            word[(1 << i) - 1] = acc;
        end
        word[NPOS] = ^word[NPOS-1:0];
    end

    assign code_o = word;

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W+chk_count(DATA_W):0]  code_i,
    output logic [chk_count(DATA_W)-1:0]       syn_o,
    output logic                               par_err_o
);
    localparam int CHK_W = chk_count(DATA_W);
    localparam int NPOS  = DATA_W + CHK_W;

    // each group includes its own stored check bit, so the result is stored ^ recomputed
    always_comb begin
        for (int i = 0; i < CHK_W; i++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 1; p <= NPOS; p++) begin
                if ((p & (1 << i)) != 0) acc = acc ^ code_i[p - 1];
            end
            syn_o[i] = acc;
        end
    end

    assign par_err_o = ^code_i;

endmodule

// File: rtl/secded_classifier.sv
module secded_classifier
    import secded_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W+chk_count(DATA_W):0]  code_i,
    input  logic [chk_count(DATA_W)-1:0]       syn_i,
    input  logic                               par_err_i,
    output logic [DATA_W-1:0]                  data_o,
    output dec_verdict_e                       verdict_o
);
    localparam int CHK_W = chk_count(DATA_W);
    localparam int NPOS  = DATA_W + CHK_W;

    logic [NPOS:0]     fixed;
    logic [DATA_W-1:0] raw_data;
    logic              syn_nz;
    logic              unused_chk_bits;

    assign syn_nz = |syn_i;

    always_comb begin
        fixed     = code_i;
        verdict_o = DEC_CLEAN;
        unique case ({syn_nz, par_err_i})
            2'b00: verdict_o = DEC_CLEAN;
            2'b01: begin
                verdict_o   = DEC_FIXED;
                fixed[NPOS] = ~code_i[NPOS];
            end
            2'b11: begin
                if (int'(syn_i) <= NPOS) begin
                    verdict_o               = DEC_FIXED;
                    fixed[int'(syn_i) - 1]  = ~code_i[int'(syn_i) - 1];
                end else begin
                    verdict_o = DEC_DOUBLE;
                end
            end
            default: verdict_o = DEC_DOUBLE;
        endcase
    end

    always_comb begin
        for (int j = 0; j < DATA_W; j++) begin
            data_o[j]   = fixed[data_pos(j) - 1];
            raw_data[j] = code_i[data_pos(j) - 1];
        end
    end

    assign unused_chk_bits = ^fixed;

    always_comb begin
        if (!$isunknown({code_i, syn_i, par_err_i, data_o, raw_data})) begin
            assert_clean_passthru_R4: assert (syn_nz || par_err_i || (data_o == raw_data && verdict_o == DEC_CLEAN))
                else $error("clean word altered");
            assert_parity_only_keeps_data_R6: assert (syn_nz || !par_err_i || (data_o == raw_data && verdict_o == DEC_FIXED))
                else $error("parity-only error changed data");
            assert_double_raw_R7: assert (!(syn_nz && !par_err_i) || (data_o == raw_data && verdict_o == DEC_DOUBLE))
                else $error("double error not passed raw");
            assert_single_flip_R5: assert (!(syn_nz && par_err_i) || verdict_o != DEC_CLEAN)
                else $error("single error reported clean");
        end
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W = 4,
    localparam int CHK_W  = chk_count(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CODE_W-1:0] code_out,
    input  logic [CODE_W-1:0] code_in,
    output logic [DATA_W-1:0] data_out,
    output logic              no_err,
    output logic              corrected,
    output logic              double_err
);
    logic [CHK_W-1:0] syn;
    logic             par_err;
    dec_verdict_e     verdict;

    secded_encoder #(.DATA_W(DATA_W)) enc_i (
        .data_i (data_in),
        .code_o (code_out)
    );

    secded_syndrome #(.DATA_W(DATA_W)) syn_i (
        .code_i    (code_in),
        .syn_o     (syn),
        .par_err_o (par_err)
    );

    secded_classifier #(.DATA_W(DATA_W)) cls_i (
        .code_i    (code_in),
        .syn_i     (syn),
        .par_err_i (par_err),
        .data_o    (data_out),
        .verdict_o (verdict)
    );

    assign no_err     = (verdict == DEC_CLEAN);
    assign corrected  = (verdict == DEC_FIXED);
    assign double_err = (verdict == DEC_DOUBLE);

    always_comb begin
        if (!$isunknown(code_in)) begin
            assert_one_verdict_R8: assert ($onehot({no_err, corrected, double_err}))
                else $error("status not one-hot");
        end
    end

endmodule

// File: tb/secded_codec_tb.sv
module secded_codec_tb_top;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] data_in;
    logic [7:0] code_out;
    logic [7:0] code_in;
    logic [3:0] data_out;
    logic       no_err, corrected, double_err;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    secded_codec #(.DATA_W(4)) dut_i (
        .data_in    (data_in),
        .code_out   (code_out),
        .code_in    (code_in),
        .data_out   (data_out),
        .no_err     (no_err),
        .corrected  (corrected),
        .double_err (double_err)
    );

    function automatic logic [7:0] ref_enc(input logic [3:0] d);
        logic c1, c2, c3;
        logic [6:0] w;
        c1 = d[0] ^ d[1] ^ d[3];
        c2 = d[0] ^ d[2] ^ d[3];
        c3 = d[1] ^ d[2] ^ d[3];
        w  = {d[3], d[2], d[1], c3, d[0], c2, c1};
        return {^w, w};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] d, input logic [7:0] c);
        @(negedge clk);
        data_in = d;
        code_in = c;
        @(posedge clk);
        #1;
    endtask

    // status packed as {no_err, corrected, double_err}
    task automatic check_dec(input string req, input logic [2:0] exp_st, input logic [3:0] exp_d);
        check(data_out == exp_d, req, {28'd0, data_out}, {28'd0, exp_d});
        check({no_err, corrected, double_err} == exp_st, req,
              {29'd0, no_err, corrected, double_err}, {29'd0, exp_st});
        check($onehot({no_err, corrected, double_err}), "R8",
              {29'd0, no_err, corrected, double_err}, 32'd1);
    endtask

    initial begin
        data_in = '0;
        code_in = '0;
        apply(4'h0, 8'h00);
        check(code_out == 8'h00, "R3 zero word", {24'd0, code_out}, 32'h0);
        check_dec("R4 zero word", 3'b100, 4'h0);

        apply(4'b0110, ref_enc(4'b0110));
        check(code_out == 8'h33, "R9", {24'd0, code_out}, 32'h33);
        // d2 flip (syndrome 5) and c2 flip (syndrome 2)
        apply(4'b0110, 8'h33 ^ 8'h10);
        check_dec("R5 d2 flip", 3'b010, 4'b0110);
        apply(4'b0110, 8'h33 ^ 8'h02);
        check_dec("R5 c2 flip", 3'b010, 4'b0110);

        for (int v = 0; v < 16; v++) begin
            logic [7:0] cw;
            cw = ref_enc(v[3:0]);
            apply(v[3:0], cw);
            check(code_out == cw, "R1 R2 encode", {24'd0, code_out}, {24'd0, cw});
            check(^code_out == 1'b0, "R3 parity", {31'd0, ^code_out}, 32'd0);
            check_dec("R4 clean", 3'b100, v[3:0]);
            for (int b = 0; b < 8; b++) begin
                apply(v[3:0], cw ^ (8'd1 << b));
                if (b == 7) check_dec("R6 parity bit", 3'b010, v[3:0]);
                else        check_dec("R5 single", 3'b010, v[3:0]);
            end
            for (int a = 0; a < 8; a++) begin
                for (int b = a + 1; b < 8; b++) begin
                    logic [7:0] rx;
                    rx = cw ^ (8'd1 << a) ^ (8'd1 << b);
                    apply(v[3:0], rx);
                    check_dec("R7 double", 3'b001, {rx[6], rx[5], rx[4], rx[2]});
                end
            end
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 50000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule